// File: doc/BRIEF.md
# Hardware Context Priority Scheduler

This block decides, on every clock, which of five hardware execution contexts owns the CPU pipeline. Each context keeps its own state, so moving from one to another needs no save or restore. Software sets three things for each context: a mode, a 3-bit priority and a flag that pauses DMA. It also sets a routing field for each interrupt source. The scheduler latches incoming interrupts against their target contexts. It picks the ready context with the highest priority and registers that choice as the active context.

When a context with the DMA-pause flag is active, the block withholds DMA grants by itself. Grants return as soon as that context stops running. The block also drives a protection-set selector for an external protection checker. The selector names the active context, or the DMA channel when a DMA transfer holds the bus.

Writes that would change the configuration of the running context are not lost. They are parked in a single deferral slot and take effect once that context is no longer active.

Top module: `ctx_sched`

## Requirements
- R1: After reset, `active_ctx` is 0 and `idle` is 1. Every context is in full-thread mode with priority 0 and no DMA pause, every interrupt routes to context 0, and nothing is pending.
- R2: The next active context is the ready context with the highest priority. Ties go to the lowest context index.
- R3: The scheduling decision made from a cycle's inputs shows on `active_ctx`/`idle` only after the next rising clock edge. The outputs change only at that edge.
- R4: A write to address c (0..4) sets context c. The fields are `wr_data[1:0]` = mode, `wr_data[4:2]` = priority and `wr_data[5]` = DMA-pause flag. The modes are 0 = full thread, 1 = interrupt context, 2 = dedicated loop and 3 = treated as full thread. A full thread is ready when its `ctx_ready` bit is set or it has a pending interrupt. An interrupt context is ready only when it has a pending interrupt. A dedicated loop is ready only when its `ctx_ready` bit is set. Writes to addresses 5..7 are ignored.
- R5: A write to address 8+i sets the target context of interrupt source i to `wr_data[2:0]`. A target of 5 or more rejects the write. A cycle with `irq[i]` high latches source i as pending for its target context. Without an interrupt, the number of pending sources never grows.
- R6: A context in dedicated-loop mode never takes interrupts, and interrupts routed to it are discarded. A routing write whose target is in dedicated-loop mode, as judged when the write is applied, is rejected and leaves the routing unchanged.
- R7: When the active context asserts its `ctx_yield` bit, the lowest-index pending source routed to it is cleared. Any other pending sources stay latched and keep it ready. Yield bits of contexts that are not active have no effect.
- R8: When no context is ready, `idle` is 1 and `active_ctx` is 0.
- R9: `dma_gnt` equals `dma_req`, except that it is 0 while `idle` is 0 and the active context has its DMA-pause flag set.
- R10: `prot_sel` is 5 + `dma_ch` while `dma_gnt` is 1, and otherwise equals `active_ctx`.
- R11: A write that affects the active context while `idle` is 0 is held in one deferral slot, and a newer such write replaces it. For a configuration write the affected context is its address. For a routing write it is the target. The held write is applied in the first cycle in which that context is not active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write address: 0..4 context setup, 8..15 interrupt routing |
| wr_data | input | 6 | Write data |
| irq | input | 8 | Interrupt requests, one per source |
| ctx_ready | input | 5 | Per-context ready request |
| ctx_yield | input | 5 | Per-context yield, effective for the active context |
| dma_req | input | 1 | DMA bus request |
| dma_ch | input | 2 | Channel of the requesting DMA transfer |
| dma_gnt | output | 1 | DMA bus grant |
| active_ctx | output | 3 | Context that owns the pipeline |
| idle | output | 1 | No context is ready |
| prot_sel | output | 4 | Protection region set selector |

## Verification
Several fixed patterns come first. Two equal-priority ready contexts test the tie rule, a higher-priority context that appears later tests preemption, and a check taken before the edge tests the one-cycle switch delay. Two interrupts queued on one interrupt context show that one yield clears only one of them. A priority write made while its context runs must leave arbitration unchanged until the context leaves, and then change it. Interrupts and routing writes aimed at a dedicated-loop context separate discarding from latching. DMA requests before and after a DMA-pausing context becomes active separate the grant and selector behaviour. A long random mix of ready, yield, interrupt, DMA and write traffic is then compared every cycle against a behavioural model.

// File: rtl/ctx_sched_pkg.sv
package ctx_sched_pkg;
    typedef enum logic [1:0] {
        MODE_FULL = 2'd0,
        MODE_IRQ  = 2'd1,
        MODE_LOOP = 2'd2,
        MODE_RSVD = 2'd3
    } ctx_mode_e;
endpackage

// File: rtl/ctx_cfg_regs.sv
module ctx_cfg_regs
    import ctx_sched_pkg::*;
#(
    parameter int NUM_CTX = 5,
    parameter int NUM_IRQ = 8,
    parameter int PRIO_W  = 3,
    parameter int ADDR_W  = 4,
    localparam int CTX_W      = $clog2(NUM_CTX),
    localparam int DATA_W     = 3 + PRIO_W,
    localparam int ROUTE_BASE = 2 ** (ADDR_W - 1)
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en,
    input  logic [ADDR_W-1:0]                 wr_addr,
    input  logic [DATA_W-1:0]                 wr_data,
    input  logic [CTX_W-1:0]                  act_ctx,
    input  logic                              act_valid,
    output logic [NUM_CTX-1:0][1:0]           mode_o,
    output logic [NUM_CTX-1:0][PRIO_W-1:0]    prio_o,
    output logic [NUM_CTX-1:0]                hi_o,
    output logic [NUM_IRQ-1:0][CTX_W-1:0]     route_o
);
    typedef struct packed {
        logic [NUM_CTX-1:0][1:0]        mode;
        logic [NUM_CTX-1:0][PRIO_W-1:0] prio;
        logic [NUM_CTX-1:0]             hi;
        logic [NUM_IRQ-1:0][CTX_W-1:0]  route;
        logic                           slot_v;
        logic [ADDR_W-1:0]              slot_a;
        logic [DATA_W-1:0]              slot_d;
    } cfg_t;

    cfg_t q, d;
    logic [CTX_W:0] sdec, wdec;

    // returns {legal, affected context}
    function automatic logic [CTX_W:0] decode(input logic [ADDR_W-1:0] a,
                                              input logic [DATA_W-1:0] dat);
        logic ok;
        logic [CTX_W-1:0] c;
        if (int'(a) < ROUTE_BASE) begin
            ok = int'(a) < NUM_CTX;
            c  = a[CTX_W-1:0];
        end else begin
            ok = ((int'(a) - ROUTE_BASE) < NUM_IRQ) && (int'(dat[CTX_W-1:0]) < NUM_CTX);
            c  = dat[CTX_W-1:0];
        end
        return {ok, c};
    endfunction

    function automatic cfg_t put(input cfg_t s, input logic [NUM_CTX-1:0][1:0] mref,
                                 input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] dat);
        cfg_t r;
        logic [CTX_W-1:0] tgt;
        r   = s;
        tgt = dat[CTX_W-1:0];
        if (int'(a) < ROUTE_BASE) begin
            r.mode[a[CTX_W-1:0]] = dat[1:0];
            r.prio[a[CTX_W-1:0]] = dat[2 +: PRIO_W];
            r.hi[a[CTX_W-1:0]]   = dat[2 + PRIO_W];
        end else if (mref[tgt] != 2'(MODE_LOOP)) begin
            r.route[a[ADDR_W-2:0]] = tgt;
        end
        return r;
    endfunction

    always_comb begin
        d    = q;
        sdec = decode(q.slot_a, q.slot_d);
        wdec = decode(wr_addr, wr_data);
        if (q.slot_v && !(act_valid && sdec[CTX_W-1:0] == act_ctx)) begin
            if (sdec[CTX_W]) d = put(d, q.mode, q.slot_a, q.slot_d);
            d.slot_v = 1'b0;
        end
        if (wr_en && wdec[CTX_W]) begin
            if (act_valid && wdec[CTX_W-1:0] == act_ctx) begin
                d.slot_v = 1'b1;
                d.slot_a = wr_addr;
                d.slot_d = wr_data;
            end else begin
                d = put(d, q.mode, wr_addr, wr_data);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign mode_o  = q.mode;
    assign prio_o  = q.prio;
    assign hi_o    = q.hi;
    assign route_o = q.route;

    // R6
    route_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wdec[CTX_W] && int'(wr_addr) >= ROUTE_BASE && !q.slot_v
         && q.mode[wr_data[CTX_W-1:0]] == 2'(MODE_LOOP)
         && !(act_valid && wdec[CTX_W-1:0] == act_ctx)) |=> $stable(q.route));

    // R11
    slot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.slot_v && act_valid && sdec[CTX_W-1:0] == act_ctx) |=> q.slot_v);
endmodule

// File: rtl/ctx_irq_latch.sv
module ctx_irq_latch
    import ctx_sched_pkg::*;
#(
    parameter int NUM_CTX = 5,
    parameter int NUM_IRQ = 8,
    localparam int CTX_W = $clog2(NUM_CTX)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_IRQ-1:0]            irq,
    input  logic [NUM_IRQ-1:0][CTX_W-1:0] route,
    input  logic [NUM_CTX-1:0][1:0]       mode,
    input  logic [CTX_W-1:0]              act_ctx,
    input  logic                          act_valid,
    input  logic                          yield_act,
    output logic [NUM_CTX-1:0]            ctx_pend
);
    typedef struct packed {
        logic [NUM_IRQ-1:0] pend;
    } lat_t;

    lat_t q, d;
    logic [NUM_IRQ-1:0] blocked, setv, clr;
    logic found;

    always_comb begin
        clr   = '0;
        found = 1'b0;
        for (int i = 0; i < NUM_IRQ; i++) begin
            blocked[i] = (mode[route[i]] == 2'(MODE_LOOP));
        end
        setv = (q.pend | irq) & ~blocked;
        if (act_valid && yield_act) begin
            for (int i = 0; i < NUM_IRQ; i++) begin
                if (!found && q.pend[i] && route[i] == act_ctx) begin
                    clr[i] = 1'b1;
                    found  = 1'b1;
                end
            end
        end
        d.pend = setv & ~clr;
        for (int c = 0; c < NUM_CTX; c++) begin
            ctx_pend[c] = 1'b0;
            for (int i = 0; i < NUM_IRQ; i++) begin
                if (d.pend[i] && route[i] == CTX_W'(c)) ctx_pend[c] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R5
    pend_no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(|irq) |=> $countones(q.pend) <= $past($countones(q.pend)));
endmodule

// File: rtl/ctx_arbiter.sv
module ctx_arbiter #(
    parameter int NUM_CTX = 5,
    parameter int PRIO_W  = 3,
    localparam int CTX_W = $clog2(NUM_CTX)
) (
    input  logic [NUM_CTX-1:0]             ready,
    input  logic [NUM_CTX-1:0][PRIO_W-1:0] prio,
    output logic [CTX_W-1:0]               win,
    output logic                           any
);
    logic [PRIO_W-1:0] best;

    always_comb begin
        any  = 1'b0;
        win  = '0;
        best = '0;
        for (int c = 0; c < NUM_CTX; c++) begin
            if (ready[c] && (!any || prio[c] > best)) begin
                any  = 1'b1;
                win  = CTX_W'(c);
                best = prio[c];
            end
        end
    end
endmodule

// File: rtl/ctx_sched.sv
module ctx_sched
    import ctx_sched_pkg::*;
#(
    parameter int NUM_CTX = 5,
    parameter int NUM_IRQ = 8,
    parameter int PRIO_W  = 3,
    parameter int ADDR_W  = 4,
    parameter int NUM_DMA = 4,
    localparam int CTX_W  = $clog2(NUM_CTX),
    localparam int DATA_W = 3 + PRIO_W,
    localparam int DMA_W  = $clog2(NUM_DMA),
    localparam int SEL_W  = $clog2(NUM_CTX + NUM_DMA)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic [NUM_IRQ-1:0] irq,
    input  logic [NUM_CTX-1:0] ctx_ready,
    input  logic [NUM_CTX-1:0] ctx_yield,
    input  logic               dma_req,
    input  logic [DMA_W-1:0]   dma_ch,
    output logic               dma_gnt,
    output logic [CTX_W-1:0]   active_ctx,
    output logic               idle,
    output logic [SEL_W-1:0]   prot_sel
);
    typedef struct packed {
        logic [CTX_W-1:0] act;
        logic             idle;
    } run_t;

    run_t q, d;

    logic [NUM_CTX-1:0][1:0]        mode;
    logic [NUM_CTX-1:0][PRIO_W-1:0] prio;
    logic [NUM_CTX-1:0]             hi;
    logic [NUM_IRQ-1:0][CTX_W-1:0]  route;
    logic [NUM_CTX-1:0]             ctx_pend, ready;
    logic [CTX_W-1:0]               win;
    logic                           any_rdy, yield_act, pause;

    assign yield_act = ctx_yield[q.act];

    ctx_cfg_regs #(.NUM_CTX(NUM_CTX), .NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W), .ADDR_W(ADDR_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .act_ctx(q.act), .act_valid(!q.idle),
        .mode_o(mode), .prio_o(prio), .hi_o(hi), .route_o(route)
    );

    ctx_irq_latch #(.NUM_CTX(NUM_CTX), .NUM_IRQ(NUM_IRQ)) u_irq (
        .clk(clk), .rst_n(rst_n), .irq(irq), .route(route), .mode(mode),
        .act_ctx(q.act), .act_valid(!q.idle), .yield_act(yield_act), .ctx_pend(ctx_pend)
    );

    always_comb begin
        for (int c = 0; c < NUM_CTX; c++) begin
            unique case (ctx_mode_e'(mode[c]))
                MODE_IRQ:  ready[c] = ctx_pend[c];
                MODE_LOOP: ready[c] = ctx_ready[c];
                default:   ready[c] = ctx_ready[c] | ctx_pend[c];
            endcase
        end
    end

    ctx_arbiter #(.NUM_CTX(NUM_CTX), .PRIO_W(PRIO_W)) u_arb (
        .ready(ready), .prio(prio), .win(win), .any(any_rdy)
    );

    always_comb begin
        d.act  = any_rdy ? win : '0;
        d.idle = !any_rdy;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.act  <= '0;
            q.idle <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign pause      = !q.idle && hi[q.act];
    assign dma_gnt    = dma_req && !pause;
    assign active_ctx = q.act;
    assign idle       = q.idle;
    assign prot_sel   = dma_gnt ? (SEL_W'(NUM_CTX) + SEL_W'(dma_ch)) : SEL_W'(q.act);

    // R3
    switch_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
        any_rdy |=> !idle);

    // R8
    idle_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !any_rdy |=> (idle && active_ctx == '0));

    // R9
    dma_pause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!idle && hi[active_ctx]) |-> !dma_gnt);

    // R10
    prot_dma_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dma_gnt |-> (int'(prot_sel) >= NUM_CTX));
endmodule

// File: tb/ctx_sched_tb.sv
`timescale 1ns/1ps
module ctx_sched_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [3:0] wr_addr = '0;
    logic [5:0] wr_data = '0;
    logic [7:0] irq = '0;
    logic [4:0] ctx_ready = '0;
    logic [4:0] ctx_yield = '0;
    logic       dma_req = 1'b0;
    logic [1:0] dma_ch = '0;
    logic       dma_gnt;
    logic [2:0] active_ctx;
    logic       idle;
    logic [3:0] prot_sel;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    ctx_sched u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .irq(irq), .ctx_ready(ctx_ready), .ctx_yield(ctx_yield), .dma_req(dma_req),
        .dma_ch(dma_ch), .dma_gnt(dma_gnt), .active_ctx(active_ctx), .idle(idle),
        .prot_sel(prot_sel)
    );

    // behavioural reference state
    int m_mode[5], m_prio[5], m_hi[5], m_route[8];
    bit m_pend[8];
    int m_act;
    bit m_idle;
    bit m_sv;
    int m_sa, m_sd;

    task automatic chk(string tag, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        for (int c = 0; c < 5; c++) begin m_mode[c] = 0; m_prio[c] = 0; m_hi[c] = 0; end
        for (int i = 0; i < 8; i++) begin m_route[i] = 0; m_pend[i] = 0; end
        m_act = 0; m_idle = 1; m_sv = 0; m_sa = 0; m_sd = 0;
    endtask

    function automatic bit legal(int a, int dat, output int c);
        if (a < 8) begin c = a; return a < 5; end
        c = dat % 8;
        return c < 5;
    endfunction

    task automatic mwrite(int a, int dat, ref int nm[5], ref int np[5], ref int nh[5], ref int nr[8]);
        if (a < 8) begin
            nm[a] = dat % 4; np[a] = (dat / 4) % 8; nh[a] = (dat / 32) % 2;
        end else if (m_mode[dat % 8] != 2) begin
            nr[a - 8] = dat % 8;
        end
    endtask

    task automatic model_step();
        int nm[5], np[5], nh[5], nr[8];
        bit npend[8];
        bit rdy[5];
        int c, best;
        bit nsv;
        int nsa, nsd;
        nm = m_mode; np = m_prio; nh = m_hi; nr = m_route;
        nsv = m_sv; nsa = m_sa; nsd = m_sd;
        if (m_sv) begin
            bit ok = legal(m_sa, m_sd, c);
            if (!(!m_idle && c == m_act)) begin
                if (ok) mwrite(m_sa, m_sd, nm, np, nh, nr);
                nsv = 0;
            end
        end
        if (wr_en) begin
            if (legal(int'(wr_addr), int'(wr_data), c)) begin
                if (!m_idle && c == m_act) begin
                    nsv = 1; nsa = int'(wr_addr); nsd = int'(wr_data);
                end else begin
                    mwrite(int'(wr_addr), int'(wr_data), nm, np, nh, nr);
                end
            end
        end
        for (int i = 0; i < 8; i++)
            npend[i] = (m_pend[i] || irq[i]) && (m_mode[m_route[i]] != 2);
        if (!m_idle && ctx_yield[m_act]) begin
            for (int i = 0; i < 8; i++) begin
                if (m_pend[i] && m_route[i] == m_act) begin npend[i] = 0; break; end
            end
        end
        for (int k = 0; k < 5; k++) begin
            bit hp = 0;
            for (int i = 0; i < 8; i++) if (npend[i] && m_route[i] == k) hp = 1;
            if (m_mode[k] == 1)      rdy[k] = hp;
            else if (m_mode[k] == 2) rdy[k] = ctx_ready[k];
            else                     rdy[k] = ctx_ready[k] || hp;
        end
        best = -1;
        for (int k = 0; k < 5; k++)
            if (rdy[k] && (best < 0 || m_prio[k] > m_prio[best])) best = k;
        m_act = (best < 0) ? 0 : best;
        m_idle = (best < 0);
        m_mode = nm; m_prio = np; m_hi = nh; m_route = nr;
        m_pend = npend; m_sv = nsv; m_sa = nsa; m_sd = nsd;
    endtask

    task automatic compare();
        int eg, es;
        eg = (dma_req && !(!m_idle && m_hi[m_act] != 0)) ? 1 : 0;
        es = eg ? 5 + int'(dma_ch) : m_act;
        chk("R2 model active_ctx", int'(active_ctx), m_act);
        chk("R8 model idle", int'(idle), int'(m_idle));
        chk("R9 model dma_gnt", int'(dma_gnt), eg);
        chk("R10 model prot_sel", int'(prot_sel), es);
    endtask

    // one cycle: inputs already set at this negedge
    task automatic tick();
        #1;
        compare();
        model_step();
        @(negedge clk);
    endtask

    task automatic wr(int a, int dat);
        wr_en = 1'b1; wr_addr = 4'(a); wr_data = 6'(dat);
        tick();
        wr_en = 1'b0;
    endtask

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 reset active_ctx", int'(active_ctx), 0);
        chk("R1 reset idle", int'(idle), 1);
        chk("R1 reset dma_gnt", int'(dma_gnt), 0);
        dma_req = 1'b1; dma_ch = 2'd1;
        #1;
        chk("R10 grant selector idle", int'(prot_sel), 6);
        dma_req = 1'b0;
        @(negedge clk);
        model_step();

        wr(1, 3 << 2);
        wr(2, 3 << 2);
        wr(3, (5 << 2) | 32);
        wr(4, 1 | (7 << 2));
        ctx_ready = 5'b00110;
        tick();
        chk("R2 tie lowest index", int'(active_ctx), 1);
        ctx_ready = 5'b01110;
        #1;
        chk("R3 no switch before edge", int'(active_ctx), 1);
        tick();
        chk("R2 higher priority wins", int'(active_ctx), 3);
        dma_req = 1'b1; dma_ch = 2'd2;
        #1;
        chk("R9 grant withheld", int'(dma_gnt), 0);
        chk("R10 selector active ctx", int'(prot_sel), 3);
        ctx_ready = 5'b00000;
        tick();
        chk("R8 idle raised", int'(idle), 1);
        chk("R8 idle reports ctx0", int'(active_ctx), 0);
        chk("R9 grant resumes", int'(dma_gnt), 1);
        chk("R10 selector dma channel", int'(prot_sel), 7);
        dma_req = 1'b0;

        wr(8 + 2, 4);
        wr(8 + 5, 4);
        irq = 8'b0010_0100;
        tick();
        irq = '0;
        chk("R5 routed irq activates ctx4", int'(active_ctx), 4);
        ctx_yield = 5'b10000;
        tick();
        ctx_yield = '0;
        chk("R7 second pending keeps ctx4", int'(active_ctx), 4);
        ctx_ready = 5'b00010;
        wr(4, 1);
        chk("R11 deferred priority not applied", int'(active_ctx), 4);
        ctx_yield = 5'b10000;
        tick();
        ctx_yield = '0;
        chk("R7 last pending cleared", int'(active_ctx), 1);
        tick();
        irq = 8'b0000_0100;
        tick();
        irq = '0;
        chk("R11 deferred priority applied", int'(active_ctx), 1);
        ctx_ready = '0;
        tick();
        chk("R4 irq context runs on pending", int'(active_ctx), 4);
        ctx_yield = 5'b10000;
        tick();
        ctx_yield = '0;
        chk("R7 yield returns to idle", int'(idle), 1);

        wr(8 + 3, 2);
        wr(0, 2);
        wr(8 + 3, 0);
        irq = 8'b0000_1000;
        tick();
        irq = '0;
        chk("R6 rejected route kept", int'(active_ctx), 2);
        ctx_yield = 5'b00100;
        tick();
        ctx_yield = '0;
        chk("R7 full thread yield", int'(idle), 1);
        irq = 8'b0000_0001;
        tick();
        irq = '0;
        tick();
        chk("R6 irq to dedicated discarded", int'(idle), 1);
        ctx_ready = 5'b10000;
        tick();
        chk("R4 irq context ignores ready", int'(idle), 1);
        ctx_ready = 5'b00001;
        tick();
        chk("R4 dedicated runs on ready", int'(idle), 0);
        chk("R4 dedicated active", int'(active_ctx), 0);
        ctx_ready = '0;
        tick();

        for (int n = 0; n < 3000; n++) begin
            ctx_ready = 5'($urandom);
            irq       = ($urandom % 4 == 0) ? 8'($urandom) : 8'h00;
            ctx_yield = ($urandom % 3 == 0) ? 5'($urandom) : 5'h00;
            wr_en     = ($urandom % 6 == 0);
            wr_addr   = 4'($urandom);
            wr_data   = 6'($urandom);
            dma_req   = 1'($urandom);
            dma_ch    = 2'($urandom);
            tick();
        end
        wr_en = 1'b0;

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(200000 * 20);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL R3 watchdog actual=running expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule